// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block performs the processor context switch that begins an interrupt or exception service routine, and the reverse switch that ends one. It holds the 16-bit status word (privilege in bit 15, priority level in bits 10:8, N/Z/P condition codes in bits 2:0), the program counter, the stack register R6, and two parking registers for the user and supervisor stack pointers that are not currently live in R6.

When `accept_i` is pulsed in an idle cycle, the block enters supervisor mode. It swaps stacks if the machine was in user mode, and pushes the old status word and then the PC onto the supervisor stack. It then reads the handler address from the vector table at `VEC_BASE + vector` and loads it into the PC. The status word takes the requested priority and has its condition codes cleared. When `rti_i` is pulsed in supervisor mode, the block pops the PC and then the status word. It swaps back to the user stack only if the restored status word is a user-mode one.

Memory is reached through a single synchronous port with one cycle of read latency. Decode, the ALU and the devices are outside the block.

Top module: `intr_ctx_seq`

## Requirements
- R1: After reset, psr_o=RST_PSR, pc_o=RST_PC, r6_o=RST_USP, usp_saved_o=RST_USP, ssp_saved_o=RST_SSP, and busy_o, priv_viol_o, mem_we_o and mem_re_o are all 0.
- R2: On acceptance from user mode (psr bit 15 = 1), usp_saved_o takes the old r6_o and r6_o takes ssp_saved_o. On acceptance from supervisor mode, no stack swap happens.
- R3: On acceptance, psr bit 15 becomes 0, psr[10:8] takes prio_i, and psr[2:0] becomes 0. All other psr bits are kept.
- R4: Entry writes the old psr to address R6-1 and then the old PC to R6-2, where R6 is the value after any swap. R6 ends 2 below that value.
- R5: After the pushes, entry reads address VEC_BASE+vector_i (VEC_BASE=16'h0100) and loads the returned word into pc_o. mem_we_o and mem_re_o are never high together.
- R6: RTI reads the PC from address R6 and then the psr from R6+1, loads both, and leaves R6 increased by 2.
- R7: After RTI, if the restored psr bit 15 is 1, ssp_saved_o takes R6 and r6_o takes usp_saved_o. Otherwise r6_o keeps its value and usp_saved_o is unchanged.
- R8: busy_o is high from the cycle after an accepted request until the PC is loaded. accept_i and rti_i are ignored while busy_o is high.
- R9: rti_i in user mode raises priv_viol_o for exactly one cycle, leaves busy_o low, and changes no register.
- R10: If accept_i and rti_i are both high in an idle cycle, the entry sequence runs and the RTI is dropped.
- R11: Both entry and RTI keep busy_o high for exactly 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| accept_i | input | 1 | Interrupt/exception accepted (one-cycle pulse) |
| vector_i | input | 8 | Vector number for the accepted request |
| prio_i | input | 3 | Priority level for the handler |
| rti_i | input | 1 | Return-from-interrupt request |
| mem_rdata_i | input | 16 | Read data, valid the cycle after mem_re_o |
| mem_addr_o | output | 16 | Memory address |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_wdata_o | output | 16 | Memory write data |
| busy_o | output | 1 | Sequence in progress |
| priv_viol_o | output | 1 | RTI attempted in user mode (one-cycle pulse) |
| psr_o | output | 16 | Status word |
| pc_o | output | 16 | Program counter |
| r6_o | output | 16 | Live stack pointer |
| usp_saved_o | output | 16 | Parked user stack pointer |
| ssp_saved_o | output | 16 | Parked supervisor stack pointer |

## Verification
The two functions that can meet in one cycle are interrupt entry and return: an accept and an RTI request can arrive together in an idle cycle. The bench drives both pins high across the same clock edge while the machine is in user mode. It then judges the result at the ports:
- the status word must show supervisor mode;
- the stack must hold the two pushed words;
- the PC must equal the handler for the vector;
- no privilege-violation pulse may appear, which the dropped RTI would have raised from user mode.

A nested entry then has accept and RTI pulses injected while busy. Their absence of effect is confirmed through R6 and the PC.

// File: rtl/intr_ctx_pkg.sv
package intr_ctx_pkg;
  typedef logic [15:0] word_t;

  localparam int unsigned PSR_PRIV = 15;
  localparam int unsigned PRIO_LO  = 8;
  localparam int unsigned PRIO_W   = 3;
  localparam int unsigned CC_W     = 3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PUSH_PSR, ST_PUSH_PC, ST_VEC_RD, ST_VEC_LD,
    ST_POP_PC_RD, ST_POP_PC_LD, ST_POP_PSR_RD, ST_POP_PSR_LD
  } seq_st_e;

  function automatic word_t entry_psr(input word_t old, input logic [PRIO_W-1:0] prio);
    word_t n;
    n = old;
    n[PSR_PRIV] = 1'b0;
    n[PRIO_LO +: PRIO_W] = prio;
    n[CC_W-1:0] = '0;
    return n;
  endfunction

  function automatic word_t vec_addr(input word_t base, input logic [7:0] vec);
    return base + {8'h00, vec};
  endfunction

  function automatic word_t sp_down(input word_t sp);
    return sp - 16'd1;
  endfunction

  function automatic word_t sp_up(input word_t sp);
    return sp + 16'd1;
  endfunction
endpackage

// File: rtl/ctx_fsm.sv
module ctx_fsm
  import intr_ctx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    accept_i,
  input  logic    rti_i,
  input  logic    user_mode_i,
  output seq_st_e state_o,
  output logic    ev_enter_o,
  output logic    ev_rti_o,
  output logic    ev_viol_o,
  output logic    viol_q_o
);
  seq_st_e state_q, state_d;
  logic    idle;

  assign idle       = (state_q == ST_IDLE);
  assign ev_enter_o = idle && accept_i;
  assign ev_rti_o   = idle && !accept_i && rti_i && !user_mode_i;
  assign ev_viol_o  = idle && !accept_i && rti_i && user_mode_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (ev_enter_o)    state_d = ST_PUSH_PSR;
        else if (ev_rti_o) state_d = ST_POP_PC_RD;
      end
      ST_PUSH_PSR:   state_d = ST_PUSH_PC;
      ST_PUSH_PC:    state_d = ST_VEC_RD;
      ST_VEC_RD:     state_d = ST_VEC_LD;
      ST_VEC_LD:     state_d = ST_IDLE;
      ST_POP_PC_RD:  state_d = ST_POP_PC_LD;
      ST_POP_PC_LD:  state_d = ST_POP_PSR_RD;
      ST_POP_PSR_RD: state_d = ST_POP_PSR_LD;
      ST_POP_PSR_LD: state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      viol_q_o <= 1'b0;
    end else begin
      state_q  <= state_d;
      viol_q_o <= ev_viol_o;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/ctx_regs.sv
module ctx_regs
  import intr_ctx_pkg::*;
#(
  parameter logic [15:0] RST_PSR = 16'h8001,
  parameter logic [15:0] RST_PC  = 16'h3000,
  parameter logic [15:0] RST_USP = 16'hFE00,
  parameter logic [15:0] RST_SSP = 16'h0300
)(
  input  logic        clk,
  input  logic        rst_n,
  input  seq_st_e     state_i,
  input  logic        ev_enter_i,
  input  logic [7:0]  vector_i,
  input  logic [2:0]  prio_i,
  input  logic [15:0] mem_rdata_i,
  output logic [15:0] psr_o,
  output logic [15:0] pc_o,
  output logic [15:0] r6_o,
  output logic [15:0] usp_s_o,
  output logic [15:0] ssp_s_o,
  output logic [15:0] held_psr_o,
  output logic [7:0]  held_vec_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psr_o      <= RST_PSR;
      pc_o       <= RST_PC;
      r6_o       <= RST_USP;
      usp_s_o    <= RST_USP;
      ssp_s_o    <= RST_SSP;
      held_psr_o <= '0;
      held_vec_o <= '0;
    end else begin
      if (ev_enter_i) begin
        held_psr_o <= psr_o;
        held_vec_o <= vector_i;
        psr_o      <= entry_psr(psr_o, prio_i);
        if (psr_o[PSR_PRIV]) begin
          usp_s_o <= r6_o;
          r6_o    <= ssp_s_o;
        end
      end
      case (state_i)
        ST_PUSH_PSR, ST_PUSH_PC:     r6_o <= sp_down(r6_o);
        ST_POP_PC_RD, ST_POP_PSR_RD: r6_o <= sp_up(r6_o);
        ST_VEC_LD, ST_POP_PC_LD:     pc_o <= mem_rdata_i;
        ST_POP_PSR_LD: begin
          psr_o <= mem_rdata_i;
          if (mem_rdata_i[PSR_PRIV]) begin
            ssp_s_o <= r6_o;
            r6_o    <= usp_s_o;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ctx_memport.sv
module ctx_memport
  import intr_ctx_pkg::*;
#(
  parameter logic [15:0] VEC_BASE = 16'h0100
)(
  input  seq_st_e     state_i,
  input  logic [15:0] r6_i,
  input  logic [15:0] pc_i,
  input  logic [15:0] held_psr_i,
  input  logic [7:0]  held_vec_i,
  output logic [15:0] addr_o,
  output logic        we_o,
  output logic        re_o,
  output logic [15:0] wdata_o
);
  always_comb begin
    addr_o  = '0;
    we_o    = 1'b0;
    re_o    = 1'b0;
    wdata_o = '0;
    case (state_i)
      ST_PUSH_PSR: begin
        we_o = 1'b1; addr_o = sp_down(r6_i); wdata_o = held_psr_i;
      end
      ST_PUSH_PC: begin
        we_o = 1'b1; addr_o = sp_down(r6_i); wdata_o = pc_i;
      end
      ST_VEC_RD: begin
        re_o = 1'b1; addr_o = vec_addr(VEC_BASE, held_vec_i);
      end
      ST_POP_PC_RD, ST_POP_PSR_RD: begin
        re_o = 1'b1; addr_o = r6_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/intr_ctx_seq.sv
module intr_ctx_seq
  import intr_ctx_pkg::*;
#(
  parameter logic [15:0] RST_PSR  = 16'h8001,
  parameter logic [15:0] RST_PC   = 16'h3000,
  parameter logic [15:0] RST_USP  = 16'hFE00,
  parameter logic [15:0] RST_SSP  = 16'h0300,
  parameter logic [15:0] VEC_BASE = 16'h0100
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept_i,
  input  logic [7:0]  vector_i,
  input  logic [2:0]  prio_i,
  input  logic        rti_i,
  input  logic [15:0] mem_rdata_i,
  output logic [15:0] mem_addr_o,
  output logic        mem_we_o,
  output logic        mem_re_o,
  output logic [15:0] mem_wdata_o,
  output logic        busy_o,
  output logic        priv_viol_o,
  output logic [15:0] psr_o,
  output logic [15:0] pc_o,
  output logic [15:0] r6_o,
  output logic [15:0] usp_saved_o,
  output logic [15:0] ssp_saved_o
);
  seq_st_e     state;
  logic        ev_enter, ev_rti, ev_viol;
  logic [15:0] held_psr;
  logic [7:0]  held_vec;

  ctx_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .accept_i(accept_i), .rti_i(rti_i),
    .user_mode_i(psr_o[PSR_PRIV]), .state_o(state),
    .ev_enter_o(ev_enter), .ev_rti_o(ev_rti), .ev_viol_o(ev_viol),
    .viol_q_o(priv_viol_o)
  );

  ctx_regs #(.RST_PSR(RST_PSR), .RST_PC(RST_PC), .RST_USP(RST_USP), .RST_SSP(RST_SSP)) u_regs (
    .clk(clk), .rst_n(rst_n), .state_i(state), .ev_enter_i(ev_enter),
    .vector_i(vector_i), .prio_i(prio_i), .mem_rdata_i(mem_rdata_i),
    .psr_o(psr_o), .pc_o(pc_o), .r6_o(r6_o), .usp_s_o(usp_saved_o),
    .ssp_s_o(ssp_saved_o), .held_psr_o(held_psr), .held_vec_o(held_vec)
  );

  ctx_memport #(.VEC_BASE(VEC_BASE)) u_mem (
    .state_i(state), .r6_i(r6_o), .pc_i(pc_o), .held_psr_i(held_psr),
    .held_vec_i(held_vec), .addr_o(mem_addr_o), .we_o(mem_we_o),
    .re_o(mem_re_o), .wdata_o(mem_wdata_o)
  );

  assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/intr_ctx_seq_chk.sv
module intr_ctx_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        accept_i,
  input logic        rti_i,
  input logic [2:0]  prio_i,
  input logic        ev_enter,
  input logic        ev_rti,
  input logic        ev_viol,
  input logic        busy_o,
  input logic        priv_viol_o,
  input logic        mem_we_o,
  input logic        mem_re_o,
  input logic [15:0] mem_addr_o,
  input logic [15:0] psr_o,
  input logic [15:0] pc_o,
  input logic [15:0] r6_o,
  input logic [15:0] usp_saved_o,
  input logic [15:0] ssp_saved_o
);
  AST_ENTRY_PSR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_enter |=> !psr_o[15] && psr_o[10:8] == $past(prio_i) && psr_o[2:0] == 3'b000); // R3
  AST_ENTRY_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_enter && psr_o[15] |=> r6_o == $past(ssp_saved_o) && usp_saved_o == $past(r6_o)); // R2
  AST_ENTRY_NOSWAP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_enter && !psr_o[15] |=> $stable(r6_o) && $stable(usp_saved_o)); // R2
  AST_PUSH_PREDEC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> r6_o == $past(mem_addr_o)); // R4
  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o)); // R5
  AST_VIOL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_viol |=> priv_viol_o && !busy_o && $stable(psr_o) && $stable(pc_o) && $stable(r6_o)); // R9
  AST_BUSY_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !ev_enter && !ev_rti && !ev_viol); // R8
  AST_ACCEPT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i && rti_i && !busy_o |=> busy_o && !priv_viol_o && !psr_o[15]); // R10
endmodule

bind intr_ctx_seq intr_ctx_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .accept_i(accept_i), .rti_i(rti_i), .prio_i(prio_i),
  .ev_enter(ev_enter), .ev_rti(ev_rti), .ev_viol(ev_viol), .busy_o(busy_o),
  .priv_viol_o(priv_viol_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
  .mem_addr_o(mem_addr_o), .psr_o(psr_o), .pc_o(pc_o), .r6_o(r6_o),
  .usp_saved_o(usp_saved_o), .ssp_saved_o(ssp_saved_o)
);

// File: tb/tb_intr_ctx_seq.sv
`timescale 1ns/1ps
module tb_intr_ctx_seq;
  localparam logic [15:0] P_PSR = 16'h8001;
  localparam logic [15:0] P_PC  = 16'h3000;
  localparam logic [15:0] P_USP = 16'hFE00;
  localparam logic [15:0] P_SSP = 16'h0300;
  // stimulus table: {vector, priority, expected busy cycles}
  localparam logic [15:0] TBL [0:3] = '{
    {8'h00, 3'd7, 5'd4}, {8'h01, 3'd1, 5'd4}, {8'h80, 3'd4, 5'd4}, {8'hFF, 3'd2, 5'd4}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic accept_i = 1'b0, rti_i = 1'b0;
  logic [7:0] vector_i = '0;
  logic [2:0] prio_i = '0;
  logic [15:0] mem_rdata_i, mem_addr_o, mem_wdata_o;
  logic mem_we_o, mem_re_o, busy_o, priv_viol_o;
  logic [15:0] psr_o, pc_o, r6_o, usp_saved_o, ssp_saved_o;
  logic [15:0] stk [0:63];
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  intr_ctx_seq dut (.*);

  function automatic logic [15:0] hv(input logic [7:0] v);
    return 16'h4000 + {4'h0, v, 4'h0} + 16'd1;
  endfunction

  always @(posedge clk) begin
    if (mem_we_o) stk[mem_addr_o[5:0]] <= mem_wdata_o;
    if (mem_re_o) mem_rdata_i <= (mem_addr_o[15:8] == 8'h01) ? hv(mem_addr_o[7:0]) : stk[mem_addr_o[5:0]];
  end

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic run(input logic acc, input logic rti, input logic [7:0] v, input logic [2:0] p, output int n);
    @(negedge clk);
    accept_i = acc; rti_i = rti; vector_i = v; prio_i = p;
    @(negedge clk);
    accept_i = 1'b0; rti_i = 1'b0;
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog got=hang exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic [15:0] pc0, psr0, r60, ssp0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 psr", psr_o, P_PSR); chk("R1 pc", pc_o, P_PC); chk("R1 r6", r6_o, P_USP);
    chk("R1 usp", usp_saved_o, P_USP); chk("R1 ssp", ssp_saved_o, P_SSP);
    chk("R1 flags", {12'h0, busy_o, priv_viol_o, mem_we_o, mem_re_o}, 16'h0);
    rst_n = 1'b1;

    for (int i = 0; i < 4; i++) begin
      pc0 = pc_o; psr0 = psr_o; r60 = r6_o; ssp0 = ssp_saved_o;
      run(1'b1, 1'b0, TBL[i][15:8], TBL[i][7:5], n);
      chk("R11 entry cycles", 16'(n), {11'h0, TBL[i][4:0]});
      chk("R5 handler", pc_o, hv(TBL[i][15:8]));
      chk("R3 psr", psr_o, {1'b0, psr0[14:11], TBL[i][7:5], psr0[7:3], 3'b000});
      chk("R4 r6", r6_o, ssp0 - 16'd2);
      chk("R2 usp parked", usp_saved_o, r60);
      chk("R4 psr pushed", stk[6'(ssp0 - 16'd1)], psr0);
      chk("R4 pc pushed", stk[6'(ssp0 - 16'd2)], pc0);
      run(1'b0, 1'b1, 8'h00, 3'd0, n);
      chk("R11 rti cycles", 16'(n), 16'd4);
      chk("R6 pc", pc_o, pc0); chk("R6 psr", psr_o, psr0);
      chk("R7 r6", r6_o, r60); chk("R7 ssp", ssp_saved_o, ssp0);
    end

    // R9: RTI in user mode
    @(negedge clk); rti_i = 1'b1;
    @(negedge clk); rti_i = 1'b0;
    chk("R9 viol", {15'h0, priv_viol_o}, 16'h1);
    chk("R9 busy", {15'h0, busy_o}, 16'h0);
    chk("R9 psr", psr_o, P_PSR); chk("R9 pc", pc_o, P_PC); chk("R9 r6", r6_o, P_USP);
    @(negedge clk);
    chk("R9 one cycle", {15'h0, priv_viol_o}, 16'h0);

    // R10: accept and RTI together from user mode
    run(1'b1, 1'b1, 8'h22, 3'd3, n);
    chk("R10 psr", psr_o, 16'h0300);
    chk("R10 pc", pc_o, hv(8'h22));
    chk("R10 r6", r6_o, P_SSP - 16'd2);

    // R2/R8: nested entry from supervisor, pulses while busy ignored
    @(negedge clk); accept_i = 1'b1; vector_i = 8'h10; prio_i = 3'd6;
    @(negedge clk); accept_i = 1'b0;
    chk("R8 busy", {15'h0, busy_o}, 16'h1);
    accept_i = 1'b1; vector_i = 8'h05;
    @(negedge clk); accept_i = 1'b0; rti_i = 1'b1;
    @(negedge clk); rti_i = 1'b0;
    while (busy_o) @(negedge clk);
    chk("R8 pc", pc_o, hv(8'h10));
    chk("R2 no swap r6", r6_o, P_SSP - 16'd4);
    chk("R2 usp kept", usp_saved_o, P_USP);
    chk("R3 nested psr", psr_o, 16'h0600);

    // R7: return into supervisor keeps R6
    run(1'b0, 1'b1, 8'h00, 3'd0, n);
    chk("R7 sup r6", r6_o, P_SSP - 16'd2);
    chk("R7 sup psr", psr_o, 16'h0300);
    chk("R7 usp", usp_saved_o, P_USP);
    run(1'b0, 1'b1, 8'h00, 3'd0, n);
    chk("R7 user r6", r6_o, P_USP);
    chk("R7 user ssp", ssp_saved_o, P_SSP);
    chk("R6 final pc", pc_o, P_PC);
    chk("R6 final psr", psr_o, P_PSR);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule